// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 1M words by 4 bits. The host hands it one word request at a time through a valid/ready handshake, with a read/write flag, a 20-bit address and 4 bits of write data. The block turns each request into the active-low chip-select, output-enable and write-enable sequence the RAM needs. For reads it returns the word with a one-cycle valid strobe.

Every phase length is a whole number of system clock cycles. Each is the ceiling of the RAM's minimum time in picoseconds divided by the clock period in picoseconds, and all of these are parameters. Writes are controlled by write-enable, with output-enable held high for the whole write, so the RAM never drives the bus while the block does. The bus driver is only ever on while output-enable is high. After a read, a deselected turnaround phase always comes before the next access.

The state machine has six states:
- `ST_IDLE`: deselected and ready.
- `ST_RD_ACT`: chip and outputs enabled, `RD_CYC` cycles.
- `ST_RD_OFF`: deselected turnaround, `OFF_CYC` cycles.
- `ST_WR_SETUP`: chip selected and data driven, one cycle.
- `ST_WR_PULSE`: write-enable low, `WP_CYC` cycles.
- `ST_WR_REC`: deselected with the driver off, `REC_CYC` cycles.

The transitions are:
- IDLE→RD_ACT or IDLE→WR_SETUP when a request is accepted.
- RD_ACT→RD_OFF when its count ends; the read word is captured on this transition.
- RD_OFF→IDLE when its count ends.
- WR_SETUP→WR_PULSE after its one cycle.
- WR_PULSE→WR_REC when its count ends.
- WR_REC→IDLE when its count ends.

Top module: `sram_port_ctrl`

## Requirements
- R1: During and right after reset, `req_ready`=1, `mem_cs_n`=`mem_oe_n`=`mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A request is accepted only on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in ST_IDLE, and while `req_valid` is 0 the RAM stays deselected.
- R3: A read holds CS_n=0, OE_n=0 and WE_n=1 for RD_CYC cycles, starting the cycle after acceptance. The word on `mem_dq_in` at the edge that ends this phase appears on `rd_data`, with `rd_valid`=1 for exactly that one following cycle.
- R4: After a read phase, CS_n and OE_n are both 1 for OFF_CYC cycles before `req_ready` returns to 1.
- R5: A write first spends one cycle with CS_n=0, OE_n=1, WE_n=1 and the data driven. It then holds WE_n=0 for WP_CYC cycles. OE_n stays 1 whenever WE_n is 0.
- R6: A write ends with CS_n and WE_n rising on the same edge and the driver turning off on that same edge. REC_CYC deselected cycles follow before `req_ready` returns to 1.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: `mem_addr` is stable for as long as CS_n stays 0, and `mem_dq_out` is stable for as long as `mem_dq_oe` stays 1.
- R9: A read of an address returns the word most recently written there, across arbitrary addresses including 0x00000 and 0xFFFFF.
- R10: Every rise of `mem_dq_oe` comes after a cycle with CS_n=1, OE_n=1 and `mem_dq_oe`=0.
- R11: With the default 8000 ps clock and RAM times (10 ns read, 5 ns output-off, 8 ns write pulse, 10 ns write cycle), the phase counts are RD_CYC=2, OFF_CYC=1, WP_CYC=1 and REC_CYC=1. Every access therefore takes four cycles from acceptance back to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Word to write |
| rd_data | output | 4 | Word returned by the last read |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| mem_addr | output | 20 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 4 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data driver toward the RAM |
| mem_dq_in | input | 4 | Data from the RAM |

## Verification
Take the acceptance edge as E0. All RAM controls change on the edges that follow it. Read controls are active after E0 and E1, the read word and `rd_valid` are due after E2, and ready returns after E3. For a write, setup comes after E0, the low write pulse after E1, deselect with the driver off after E2, and ready after E3. The bench drives on falling edges and compares all six control outputs at each of the four falling edges after E0 against that schedule. The RAM model only returns true data once a read has been stable for 10 ns, so sampling one cycle early shows up as an inverted word.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACT   = 3'd1,
        ST_RD_OFF   = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_REC   = 3'd5
    } sram_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_hold.sv
`timescale 1ns/1ps
module sram_req_hold #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              strobe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= cap;
            if (cap) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/sram_port_ctrl.sv
`timescale 1ns/1ps
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 4,
    parameter int CLK_PS    = 8000,
    parameter int T_RC_PS   = 10000,
    parameter int T_AA_PS   = 10000,
    parameter int T_OE_PS   = 5000,
    parameter int T_OHZ_PS  = 5000,
    parameter int T_WP_PS   = 8000,
    parameter int T_WC_PS   = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in clock cycles, each rounded up from the RAM minimum.
    localparam int RD_CYC  = imax(1, ceil_div(imax(imax(T_RC_PS, T_AA_PS), T_OE_PS), CLK_PS));
    localparam int OFF_CYC = imax(1, ceil_div(T_OHZ_PS, CLK_PS));
    localparam int WP_CYC  = imax(1, ceil_div(T_WP_PS, CLK_PS));
    localparam int WC_CYC  = ceil_div(T_WC_PS, CLK_PS);
    localparam int REC_CYC = imax(1, WC_CYC - 1 - WP_CYC);
    localparam int MAX_CYC = imax(imax(RD_CYC, OFF_CYC), imax(WP_CYC, REC_CYC));
    localparam int CNT_W   = imax(1, $clog2(MAX_CYC + 1));

    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LD = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    sram_state_e      st_q, st_d;
    logic             ld, take, cap, ph_done;
    logic [CNT_W-1:0] ld_val;

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .done     (ph_done)
    );

    sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .addr_i (req_addr),
        .data_i (req_wdata),
        .addr_q (mem_addr),
        .data_q (mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) i_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .din    (mem_dq_in),
        .dout   (rd_data),
        .strobe (rd_valid)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and phase timer loads.
    always_comb begin
        st_d   = st_q;
        ld     = 1'b0;
        ld_val = '0;
        take   = 1'b0;
        cap    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    ld   = 1'b1;
                    if (req_write) begin
                        st_d = ST_WR_SETUP;
                    end else begin
                        st_d   = ST_RD_ACT;
                        ld_val = RD_LD;
                    end
                end
            end
            ST_RD_ACT: begin
                if (ph_done) begin
                    cap    = 1'b1;
                    st_d   = ST_RD_OFF;
                    ld     = 1'b1;
                    ld_val = OFF_LD;
                end
            end
            ST_RD_OFF: begin
                if (ph_done) begin
                    st_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                st_d   = ST_WR_PULSE;
                ld     = 1'b1;
                ld_val = WP_LD;
            end
            ST_WR_PULSE: begin
                if (ph_done) begin
                    st_d   = ST_WR_REC;
                    ld     = 1'b1;
                    ld_val = REC_LD;
                end
            end
            ST_WR_REC: begin
                if (ph_done) begin
                    st_d = ST_IDLE;
                end
            end
            default: begin
                st_d = ST_IDLE;
            end
        endcase
    end

    // Registered RAM controls, decoded from the next state so they switch cleanly.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !(st_d == ST_RD_ACT || st_d == ST_WR_SETUP || st_d == ST_WR_PULSE);
            mem_oe_n  <= (st_d != ST_RD_ACT);
            mem_we_n  <= (st_d != ST_WR_PULSE);
            mem_dq_oe <= (st_d == ST_WR_SETUP || st_d == ST_WR_PULSE);
        end
    end

    assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/sram_port_ctrl_chk.sv
`timescale 1ns/1ps
module sram_port_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    p_ready_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    p_rd_strobe_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_rd_strobe_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));

    p_off_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> mem_cs_n);

    p_we_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_dq_oe));

    p_we_after_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_cs_n) && $past(mem_dq_oe) && $stable(mem_addr)));

    p_write_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_cs_n && !mem_dq_oe));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    p_turn_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_cs_n) && $past(mem_oe_n)));
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_sram_port_ctrl.sv
`timescale 1ns/1ps
module test_sram_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic [3:0]  rd_data;
    logic        rd_valid;
    logic [19:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in;

    int checks = 0;
    int failures = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    sram_port_ctrl i_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural RAM model ----------------
    logic [3:0] ram_m [int unsigned];
    int         commits = 0;
    logic       rd_act;
    logic [20:0] rkey, rkey_d;

    function automatic logic [3:0] ram_rd(input logic [19:0] a);
        if (ram_m.exists(int'(a))) return ram_m[int'(a)];
        return 4'h0;
    endfunction

    assign rd_act = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign rkey   = {rd_act, mem_addr};
    assign #10 rkey_d = rkey;   // true data only after 10 ns of stable read

    always @(mem_addr or rd_act or rkey or rkey_d or commits) begin
        if (rd_act && rkey_d == rkey) mem_dq_in = ram_rd(mem_addr);
        else                          mem_dq_in = ~ram_rd(mem_addr);
    end

    logic        wr_prev = 1'b0;
    logic [19:0] wa_prev = '0;
    logic [3:0]  wd_prev = '0;
    logic        prev_cs_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && !mem_oe_n) begin
                failures++;
                $display("FAIL R7 contention: dq_oe=%0b oe_n=%0b expected oe_n=1", mem_dq_oe, mem_oe_n);
            end
            if (!mem_we_n && !mem_oe_n) begin
                failures++;
                $display("FAIL R5 write with oe_n=%0b expected 1", mem_oe_n);
            end
            if (wr_prev && !mem_we_n && !mem_cs_n && mem_addr != wa_prev) begin
                failures++;
                $display("FAIL R8 addr moved in write: %h expected %h", mem_addr, wa_prev);
            end
            if (mem_dq_oe && !prev_dq_oe) begin
                checks++;
                if (!(prev_cs_n && prev_oe_n)) begin
                    failures++;
                    $display("FAIL R10 drive start: prev cs_n=%0b oe_n=%0b expected 1 1", prev_cs_n, prev_oe_n);
                end
            end
            if (wr_prev && !(!mem_cs_n && !mem_we_n)) begin
                ram_m[int'(wa_prev)] = wd_prev;
                commits++;
            end
        end
        wr_prev    = !mem_cs_n && !mem_we_n;
        wa_prev    = mem_addr;
        wd_prev    = mem_dq_out;
        prev_cs_n  = mem_cs_n;
        prev_oe_n  = mem_oe_n;
        prev_dq_oe = mem_dq_oe;
    end

    // ---------------- helpers ----------------
    task automatic summary_and_end();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // control vector {cs_n, oe_n, we_n, dq_oe, ready, rd_valid}
    function automatic logic [5:0] ctl_now();
        return {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid};
    endfunction

    localparam logic [5:0] RD_SEQ [4] = '{6'b001000, 6'b001000, 6'b111001, 6'b111010};
    localparam logic [5:0] WR_SEQ [4] = '{6'b011100, 6'b010100, 6'b111000, 6'b111010};

    // One access; checks all four post-acceptance cycles (R3/R4 read, R5/R6 write, R11 counts).
    task automatic do_op(input logic wr, input logic [19:0] a, input logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0;
                chk(mem_addr == a, wr ? "R5" : "R3", "address", int'(mem_addr), int'(a));
            end
            if (wr) begin
                chk(ctl_now() == WR_SEQ[i], i < 2 ? "R5" : "R6", "write ctl", int'(ctl_now()), int'(WR_SEQ[i]));
                if (i < 2) chk(mem_dq_out == d, "R8", "write data", int'(mem_dq_out), int'(d));
            end else begin
                chk(ctl_now() == RD_SEQ[i], i < 2 ? "R3" : "R4", "read ctl", int'(ctl_now()), int'(RD_SEQ[i]));
                if (i == 2) chk(rd_data == d, "R9", "read data", int'(rd_data), int'(d));
            end
        end
    endtask

    // {write, addr, data-or-expected}
    localparam logic [24:0] VEC [13] = '{
        {1'b1, 20'h00000, 4'hA}, {1'b1, 20'hFFFFF, 4'h5}, {1'b1, 20'h12345, 4'h3},
        {1'b0, 20'h00000, 4'hA}, {1'b0, 20'hFFFFF, 4'h5}, {1'b1, 20'h00000, 4'hC},
        {1'b0, 20'h00000, 4'hC}, {1'b0, 20'h12345, 4'h3}, {1'b0, 20'h0ABCD, 4'h0},
        {1'b1, 20'h0ABCD, 4'hF}, {1'b0, 20'h0ABCD, 4'hF}, {1'b1, 20'hFFFFF, 4'h0},
        {1'b0, 20'hFFFFF, 4'h0}
    };

    logic [3:0]  shadow [int unsigned];
    logic [19:0] rnd_a [24];

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        // R1: reset state, during and after reset
        repeat (3) @(negedge clk);
        chk(ctl_now() == 6'b111010, "R1", "ctl in reset", int'(ctl_now()), 'h3A);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctl_now() == 6'b111010, "R1", "ctl after reset", int'(ctl_now()), 'h3A);

        // R2: no access while valid stays low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(mem_cs_n == 1'b1, "R2", "idle cs_n", int'(mem_cs_n), 1);
        end

        // vector table
        for (int v = 0; v < 13; v++) begin
            do_op(VEC[v][24], VEC[v][23:4], VEC[v][3:0]);
        end

        // R10: read directly followed by write
        do_op(1'b0, 20'h12345, 4'h3);
        do_op(1'b1, 20'h54321, 4'h9);
        do_op(1'b0, 20'h54321, 4'h9);

        // R2: valid held high across a busy access yields exactly one read per ready
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h54321;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
        req_addr = 20'h00000;
        @(negedge clk);
        chk(mem_addr == 20'h54321, "R2", "addr ignores new req", int'(mem_addr), 'h54321);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);

        // R9: random writes then readback
        for (int i = 0; i < 24; i++) begin
            logic [3:0] dv;
            rnd_a[i] = 20'($urandom());
            dv = 4'($urandom());
            shadow[int'(rnd_a[i])] = dv;
            do_op(1'b1, rnd_a[i], dv);
        end
        for (int i = 23; i >= 0; i--) begin
            do_op(1'b0, rnd_a[i], shadow[int'(rnd_a[i])]);
        end

        // R1: reset mid-read returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(ctl_now() == 6'b111010, "R1", "ctl after mid reset", int'(ctl_now()), 'h3A);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        summary_and_end();
    end
endmodule